// File: doc/BRIEF.md
# Prioritised DMA Request Front End

This block sits between a set of peripheral request lines and the transfer datapath of a DMA engine. It watches the request lines, drops any channel that software has masked, and picks one winner. The lowest channel index always wins. It then asks the host processor for the bus with a hold request, waits for the processor to grant the bus with hold acknowledge, and only then drives the winner's active-low acknowledge together with a transfer strobe for the datapath.

Each channel has a mode bit. In single mode a service moves exactly one item and then gives the bus back. In demand mode the service keeps the bus and strobes once per cycle while the channel's request stays high. A demand service also ends when the datapath reports completion on the done input. After every service the hold request falls, and the block waits until the processor has lowered hold acknowledge before it arbitrates again. A channel that wins keeps the bus until its service ends, even when a more urgent request arrives.

Request lines can be registered through a configurable number of synchroniser stages before arbitration.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, the hold request is low, every acknowledge is high and the transfer strobe is low.
- R2: When several unmasked requests are pending at arbitration, the channel with the smallest index is served first.
- R3: A pending request raises the hold request. No acknowledge goes low and no strobe is produced while hold acknowledge stays low.
- R4: Acknowledges are active-low and one per channel. At most one is low at a time, and the winner's acknowledge is low exactly in the cycles in which the strobe is high.
- R5: A channel with mode bit 0 (single mode) gets exactly one strobe per service. The strobe is then followed by a bus release, even when its request stays high.
- R6: A channel with mode bit 1 (demand mode) gets one strobe in every consecutive cycle while its request stays high. After the request drops, exactly SYNC_STAGES further strobes follow.
- R7: In a demand service, the cycle in which the done input is high is the last strobe of that service.
- R8: A request from a higher-priority channel that arrives during a service does not change the acknowledged channel until that service has ended.
- R9: The hold request is low in the cycle after the last strobe of a service. It does not rise again while hold acknowledge is still high.
- R10: A channel whose mask bit is 1 is never served and never causes a hold request, whatever its request line does.
- R11: From an idle state, the hold request goes high SYNC_STAGES+1 clock edges after a request is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NUM_CH | Peripheral request lines, active high |
| mask_i | input | NUM_CH | Per-channel mask; 1 blocks the channel |
| demand_mode_i | input | NUM_CH | Per-channel mode; 0 single, 1 demand |
| hold_req_o | output | 1 | Bus request to the host processor |
| hold_ack_i | input | 1 | Bus grant from the host processor |
| ack_n_o | output | NUM_CH | Active-low acknowledge to each peripheral |
| xfer_strobe_o | output | 1 | One-item transfer strobe to the datapath |
| xfer_done_i | input | 1 | Datapath completion; ends a demand service |

## Verification
The bench builds the block with four channels and one synchroniser stage. One stage is the smallest setting that still puts a register between a request line and the arbiter. With it, the latency to the hold request and the extra strobe after a demand request drops are exact, nonzero values that can be checked cycle by cycle. The bench also models the host with a switchable grant. It can hold the grant low to show that nothing moves without it, and hold it high after a release to show that arbitration waits for the grant to fall.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_XFER = 2'd2,
      ST_DROP = 2'd3
   } svc_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("dma_req_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_pass
         assign sync_o = raw_i;
      end else begin : g_regs
         logic [WIDTH-1:0] pipe [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            end else begin
               pipe[0] <= raw_i;
               for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            end
         end

         assign sync_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH = 4,
   parameter int IDX_W  = 2
) (
   input  logic [NUM_CH-1:0] req_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o
);

   logic [NUM_CH:0]   seen;
   logic [NUM_CH-1:0] grant;
   logic [IDX_W-1:0]  idx_term [NUM_CH];

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
         assign seen[i+1]   = seen[i] | req_i[i];
         assign grant[i]    = req_i[i] & ~seen[i];
         assign idx_term[i] = grant[i] ? IDX_W'(i) : '0;
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_CH; i++) idx_o = idx_o | idx_term[i];
   end

   assign any_o = seen[NUM_CH];

endmodule

// File: rtl/dma_svc_fsm.sv
module dma_svc_fsm
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_any_i,
   input  logic [IDX_W-1:0]  pend_idx_i,
   input  logic [NUM_CH-1:0] req_eff_i,
   input  logic [NUM_CH-1:0] demand_mode_i,
   input  logic              hold_ack_i,
   input  logic              xfer_done_i,
   output logic              hold_req_o,
   output logic              xfer_strobe_o,
   output logic [NUM_CH-1:0] ack_n_o,
   output logic [IDX_W-1:0]  win_idx_o
);

   svc_state_e       state;
   logic [IDX_W-1:0] win_q;
   logic             demand_q;
   logic             keep_going;

   assign keep_going = demand_q & req_eff_i[win_q] & ~xfer_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         win_q    <= '0;
         demand_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (pend_any_i) begin
                  win_q    <= pend_idx_i;
                  demand_q <= demand_mode_i[pend_idx_i];
                  state    <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (hold_ack_i) state <= ST_XFER;
            end
            ST_XFER: begin
               if (!keep_going) state <= ST_DROP;
            end
            ST_DROP: begin
               if (!hold_ack_i) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign hold_req_o    = (state == ST_HOLD) || (state == ST_XFER);
   assign xfer_strobe_o = (state == ST_XFER);
   assign win_idx_o     = win_q;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ack
         assign ack_n_o[i] = ~((state == ST_XFER) && (win_q == IDX_W'(i)));
      end
   endgenerate

   // R5: a single-mode service strobes once, then leaves the transfer state
   a_r5_single_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_strobe_o && !demand_q) |=> !xfer_strobe_o);

   // R9: after a release, no new bus request while the grant is still high
   a_r9_wait_grant_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DROP && hold_ack_i) |=> !hold_req_o);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq_i,
   input  logic [NUM_CH-1:0] mask_i,
   input  logic [NUM_CH-1:0] demand_mode_i,
   output logic              hold_req_o,
   input  logic              hold_ack_i,
   output logic [NUM_CH-1:0] ack_n_o,
   output logic              xfer_strobe_o,
   input  logic              xfer_done_i
);

   localparam int IDX_W = dma_arb_pkg::idx_width(NUM_CH);

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
         $error("dma_req_arbiter: NUM_CH must be 1..16");
      end
   endgenerate

   logic [NUM_CH-1:0] req_sync;
   logic [NUM_CH-1:0] req_eff;
   logic              pend_any;
   logic [IDX_W-1:0]  pend_idx;
   logic [IDX_W-1:0]  win_idx;

   dma_req_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (dreq_i),
      .sync_o (req_sync)
   );

   assign req_eff = req_sync & ~mask_i;

   dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
      .req_i (req_eff),
      .any_o (pend_any),
      .idx_o (pend_idx)
   );

   dma_svc_fsm #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .pend_any_i    (pend_any),
      .pend_idx_i    (pend_idx),
      .req_eff_i     (req_eff),
      .demand_mode_i (demand_mode_i),
      .hold_ack_i    (hold_ack_i),
      .xfer_done_i   (xfer_done_i),
      .hold_req_o    (hold_req_o),
      .xfer_strobe_o (xfer_strobe_o),
      .ack_n_o       (ack_n_o),
      .win_idx_o     (win_idx)
   );

   // Checker helpers: winner one-hot and the channels ranked above it
   logic [NUM_CH-1:0] win_onehot;
   logic [NUM_CH-1:0] above_win;
   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         win_onehot[i] = (win_idx == IDX_W'(i));
         above_win[i]  = (IDX_W'(i) < win_idx);
      end
   end

   // R2: at arbitration no higher-ranked channel was pending
   a_r2_fixed_priority: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req_o) |-> (($past(req_eff) & above_win) == '0));

   // R10: the chosen channel was pending and unmasked
   a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req_o) |-> (($past(req_eff) & win_onehot) != '0));

   // R3: the first strobe of a service follows a granted bus
   a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_strobe_o) |-> $past(hold_ack_i));

   // R4: at most one acknowledge low, and only with the strobe
   a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ack_n_o) && ((~ack_n_o != '0) == xfer_strobe_o));

   // R7: the done cycle is the last strobe
   a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_strobe_o && xfer_done_i) |=> !xfer_strobe_o);

   // R8: the acknowledged channel is stable across back-to-back strobes
   a_r8_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_strobe_o && $past(xfer_strobe_o)) |-> $stable(ack_n_o));

   // R9: bus request falls right after the last strobe
   a_r9_hold_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_strobe_o) |-> !hold_req_o);

endmodule

// File: tb/test_dma_req_arbiter.sv
`timescale 1ns/1ps
module test_dma_req_arbiter;

   localparam int N = 4;
   localparam int S = 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] dreq = '0;
   logic [N-1:0] mask = '0;
   logic [N-1:0] dmode = '0;
   logic         hold_req;
   logic         hold_ack = 1'b0;
   logic [N-1:0] ack_n;
   logic         strobe;
   logic         done = 1'b0;

   int checks = 0;
   int errors = 0;
   int host_mode = 0; // 0 follow, 1 grant forced low, 2 grant forced high

   always #2 clk = ~clk;

   dma_req_arbiter #(.NUM_CH(N), .SYNC_STAGES(S)) i_dma_req_arbiter (
      .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .mask_i(mask),
      .demand_mode_i(dmode), .hold_req_o(hold_req), .hold_ack_i(hold_ack),
      .ack_n_o(ack_n), .xfer_strobe_o(strobe), .xfer_done_i(done)
   );

   always @(negedge clk)
      hold_ack <= (host_mode == 0) ? hold_req : (host_mode == 2);

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wait_strobe(input int limit, output bit seen);
      seen = 1'b0;
      for (int k = 0; k < limit; k++) begin
         tick();
         if (strobe) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic settle();
      host_mode = 0;
      dreq = '0;
      done = 1'b0;
      mask = '0;
      repeat (10) tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      check("R1", "hold_req in reset", hold_req, 0);
      check("R1", "ack_n in reset", ack_n, 4'hF);
      check("R1", "strobe in reset", strobe, 0);
      rst_n = 1'b1;
      repeat (3) tick();
   endtask

   task automatic t_latency_gating();
      bit seen;
      int bad = 0;
      host_mode = 1;
      dmode = '0;
      tick();
      dreq[2] = 1'b1;
      repeat (S) begin
         tick();
         check("R11", "hold_req before latency", hold_req, 0);
      end
      tick();
      check("R11", "hold_req at latency", hold_req, 1);
      for (int k = 0; k < 10; k++) begin
         tick();
         if (strobe || ack_n != 4'hF) bad++;
      end
      check("R3", "activity without grant", bad, 0);
      host_mode = 0;
      wait_strobe(8, seen);
      check("R3", "strobe after grant", seen, 1);
      check("R4", "ack_n for ch2", ack_n, 4'b1011);
      dreq[2] = 1'b0;
      tick();
      check("R9", "hold_req after last strobe", hold_req, 0);
      check("R5", "single strobe ends", strobe, 0);
      settle();
   endtask

   task automatic t_priority();
      bit seen;
      dmode = '0;
      dreq = 4'b1110;
      wait_strobe(20, seen);
      check("R2", "first winner ack_n", ack_n, 4'b1101);
      dreq[1] = 1'b0;
      wait_strobe(20, seen);
      check("R2", "second winner ack_n", ack_n, 4'b1011);
      dreq[2] = 1'b0;
      wait_strobe(20, seen);
      check("R2", "third winner ack_n", ack_n, 4'b0111);
      dreq[3] = 1'b0;
      settle();
   endtask

   task automatic t_single();
      int n_strobe = 0;
      int bad = 0;
      bit prev = 1'b0;
      dmode = '0;
      dreq[0] = 1'b1;
      for (int k = 0; k < 30; k++) begin
         tick();
         if (prev && (strobe || hold_req)) bad++;
         if (strobe) n_strobe++;
         prev = strobe;
      end
      check("R5", "back-to-back strobes or held bus", bad, 0);
      check("R5", "repeated single services", (n_strobe >= 3) ? 1 : 0, 1);
      settle();
   endtask

   task automatic t_demand_done();
      int cnt = 0;
      int bad_ack = 0;
      int gaps = 0;
      bit seen;
      dmode = 4'b0100;
      dreq[2] = 1'b1;
      wait_strobe(20, seen);
      while (strobe && cnt < 20) begin
         cnt++;
         if (ack_n != 4'b1011) bad_ack++;
         done = (cnt == 4);
         tick();
      end
      done = 1'b0;
      check("R7", "strobes up to done", cnt, 4);
      check("R6", "ack held on ch2", bad_ack, 0);
      check("R9", "hold_req after done", hold_req, 0);
      dreq[2] = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick();
         if (strobe) gaps++;
      end
      check("R6", "no strobe after end", gaps, 0);
      settle();
   endtask

   task automatic t_demand_drop();
      int cnt = 0;
      bit seen;
      dmode = 4'b1000;
      dreq[3] = 1'b1;
      wait_strobe(20, seen);
      while (strobe && cnt < 20) begin
         cnt++;
         if (cnt == 3) dreq[3] = 1'b0;
         tick();
      end
      check("R6", "strobes after request drop", cnt, 3 + S);
      settle();
   endtask

   task automatic t_no_preempt();
      int cnt = 0;
      int bad = 0;
      bit seen;
      dmode = 4'b1000;
      dreq[3] = 1'b1;
      wait_strobe(20, seen);
      while (strobe && cnt < 20) begin
         cnt++;
         if (ack_n != 4'b0111) bad++;
         if (cnt == 2) dreq[0] = 1'b1;
         if (cnt == 5) begin
            done = 1'b1;
            dreq[3] = 1'b0;
         end else begin
            done = 1'b0;
         end
         tick();
      end
      done = 1'b0;
      check("R8", "ch3 kept bus", bad, 0);
      check("R8", "ch3 service length", cnt, 5);
      wait_strobe(20, seen);
      check("R8", "ch0 served after", ack_n, 4'b1110);
      dreq[0] = 1'b0;
      settle();
   endtask

   task automatic t_mask();
      int rises = 0;
      bit seen;
      dmode = '0;
      mask = 4'b0001;
      dreq[0] = 1'b1;
      for (int k = 0; k < 15; k++) begin
         tick();
         if (hold_req || ack_n != 4'hF) rises++;
      end
      check("R10", "masked-only activity", rises, 0);
      dreq[2] = 1'b1;
      wait_strobe(20, seen);
      check("R10", "unmasked lower channel wins", ack_n, 4'b1011);
      dreq[2] = 1'b0;
      repeat (6) tick();
      rises = 0;
      for (int k = 0; k < 15; k++) begin
         tick();
         if (hold_req) rises++;
      end
      check("R10", "masked request after service", rises, 0);
      settle();
   endtask

   task automatic t_release_wait();
      int rises = 0;
      bit seen;
      dmode = '0;
      dreq[1] = 1'b1;
      wait_strobe(20, seen);
      host_mode = 2;
      for (int k = 0; k < 12; k++) begin
         tick();
         if (hold_req) rises++;
      end
      check("R9", "re-request while grant high", rises, 0);
      host_mode = 0;
      wait_strobe(20, seen);
      check("R9", "service resumes after grant low", seen, 1);
      check("R4", "ack_n for ch1", ack_n, 4'b1101);
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_latency_gating();
      t_priority();
      t_single();
      t_demand_done();
      t_demand_drop();
      t_no_preempt();
      t_mask();
      t_release_wait();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule